// File: doc/BRIEF.md
# Stacked Register Frame Engine

This block renames logical integer registers onto a physical register file that holds a fixed global region and a circular stacked region. Registers 0 to 31 are global and always map to themselves. Registers 32 to 127 address the active procedure's frame, whose size is chosen at each call. A frame lives in a circular physical buffer of `DEPTH` entries, and its bottom pointer wraps around the end of that buffer.

A call places a new frame directly above the caller's frame. A return carries the caller's frame size and moves the window back down. When a call needs more entries than the buffer has free, the engine spills the oldest resident entries to a backing memory without software help. When a return finds part of the caller's frame missing from the buffer, it fills those entries back from memory. A flush command writes every resident stacked entry to memory so that a context switch can proceed. While any of this runs, `busy` tells the pipeline to stall.

Spill data is read from the external register file, and fill data is written into it through dedicated index ports. The backing store is reached through a valid/ready port that carries an address, write data, read data and a direction bit.

Top module: `stack_frame_engine`

## Requirements
- R1: A logical register below 32 maps to the physical register with the same number and is never flagged illegal.
- R2: A logical register r of 32 or more maps to physical index 32 + ((base + r - 32) mod DEPTH) when r - 32 is less than the current frame size. Otherwise `regIllegal` is 1 and `physReg` is 0.
- R3: A call of size n (n <= DEPTH) accepted while idle moves the frame base up by the old frame size, modulo DEPTH, and sets the frame size to n. No memory traffic occurs when the resident entry count stays at or below DEPTH.
- R4: If a call leaves more than DEPTH entries resident, `busy` is 1 and the oldest entries are spilled one per accepted transfer (one per cycle while `memReady` is 1). Each spill takes its data from `rfRdData` at index `rfRdIdx`, and the address advances by one word per spill.
- R5: A return of size n moves the base down by n and sets the frame size to n. Caller entries that are no longer resident are filled from memory, lowest address first, into `rfWrIdx` with `rfWrEn` high, and the backing pointer retreats by the number of words filled.
- R6: A flush spills every resident stacked entry to memory and then leaves a frame of size 0. A later return of the old size restores the old contents.
- R7: A command is ignored while `busy` is 1. When several commands are raised together, a call wins over a return, and a return wins over a flush.
- R8: A call or return whose size exceeds DEPTH is ignored.
- R9: `memValid` is held, with the same address and direction, until `memReady` is seen. `memWrite` is 1 for spills and 0 for fills.
- R10: After reset the frame base is 0, the frame size is 0, no memory request is raised, and the first spill goes to address `BS_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| callValid | input | 1 | Allocate a new frame |
| callSize | input | 7 | Size of the new frame |
| retValid | input | 1 | Return to the caller's frame |
| retSize | input | 7 | Size of the caller's frame |
| flushValid | input | 1 | Write all resident stacked entries to memory |
| busy | output | 1 | Spill, fill or flush in progress; stall |
| logReg | input | 7 | Logical register to rename |
| physReg | output | 6 | Physical register index |
| regIllegal | output | 1 | Logical register lies outside the current frame |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memWrite | output | 1 | 1 = spill write, 0 = fill read |
| memAddr | output | 16 | Word address in backing store |
| memWData | output | 32 | Spill data |
| memRData | input | 32 | Fill data, valid during a read handshake |
| rfRdIdx | output | 6 | Register file index to spill from |
| rfRdData | input | 32 | Register file data at `rfRdIdx` |
| rfWrEn | output | 1 | Write fill data into the register file |
| rfWrIdx | output | 6 | Register file index for fill data |
| rfWrData | output | 32 | Fill data for the register file |

## Verification
The bench drives a call that overflows the buffer by four entries. A design that spilled the wrong end of the ring, or counted the overflow badly, would store the wrong words, or the wrong number of words, at addresses starting from `BS_BASE`. Renames that cross the end of the ring catch a pointer that fails to wrap. A return whose caller is partly evicted is run with a memory that is ready only every other cycle. A design that filled newest-first, dropped a handshake or restored the wrong slots would read back the caller's values wrongly. The bench also checks a flush followed by a clobbered register file and a restore, a call issued while busy, simultaneous commands, and oversized frames. A design that accepted any of these wrongly would change the legality of frame registers.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef struct packed {
    logic callAcc;
    logic retAcc;
    logic flushAcc;
    logic spillFire;
    logic fillFire;
  } sfeStrobe_t;
endpackage

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LREG_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callValid,
  input  logic [LREG_W-1:0] callSize,
  input  logic              retValid,
  input  logic [LREG_W-1:0] retSize,
  input  logic              flushValid,
  input  logic              overFull,
  input  logic              residentZero,
  input  logic              fillPending,
  input  logic              memReady,
  output sfeStrobe_t        st,
  output logic              busy,
  output logic              memValid,
  output logic              memWrite
);
  logic flushing;
  logic spillNeed;
  logic idle;
  logic callOk;
  logic retOk;

  assign spillNeed = overFull || (flushing && !residentZero);
  assign busy      = spillNeed || fillPending || flushing;
  assign idle      = !busy;
  assign callOk    = callSize <= LREG_W'(DEPTH);
  assign retOk     = retSize  <= LREG_W'(DEPTH);
  assign memValid  = spillNeed || fillPending;
  assign memWrite  = spillNeed;

  always_comb begin
    st           = '0;
    st.callAcc   = idle && callValid && callOk;
    st.retAcc    = idle && !callValid && retValid && retOk;
    st.flushAcc  = idle && !callValid && !retValid && flushValid;
    st.spillFire = spillNeed && memReady;
    st.fillFire  = fillPending && !spillNeed && memReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flushing <= 1'b0;
    else if (st.flushAcc) flushing <= 1'b1;
    else if (flushing && residentZero) flushing <= 1'b0;
  end

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(st.callAcc || st.retAcc || st.flushAcc));
  p_one_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.callAcc, st.retAcc, st.flushAcc}));
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite)));
endmodule

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int             GLOBALS = 32,
  parameter int             DEPTH   = 16,
  parameter int             LREG_W  = 7,
  parameter int             ADDR_W  = 16,
  parameter logic [15:0]    BS_BASE = 16'h0100,
  localparam int            IDX_W   = $clog2(DEPTH),
  localparam int            CNT_W   = $clog2(2 * DEPTH + 1),
  localparam int            PHYS_W  = $clog2(GLOBALS + DEPTH),
  localparam int            CMP_W   = ((LREG_W > CNT_W) ? LREG_W : CNT_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfeStrobe_t        st,
  input  logic              busy,
  input  logic [LREG_W-1:0] callSize,
  input  logic [LREG_W-1:0] retSize,
  input  logic [LREG_W-1:0] logReg,
  output logic              overFull,
  output logic              residentZero,
  output logic              fillPending,
  output logic [PHYS_W-1:0] physReg,
  output logic              regIllegal,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PHYS_W-1:0] rfRdIdx,
  output logic [PHYS_W-1:0] rfWrIdx
);
  logic [IDX_W-1:0]  base, bottom;
  logic [CNT_W-1:0]  curSize, resident, fillLeft, fillOff;
  logic [ADDR_W-1:0] bsp;

  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(a) + (CNT_W+1)'(b);
    if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
    return IDX_W'(s);
  endfunction

  function automatic logic [IDX_W-1:0] wrapSub(input logic [IDX_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return wrapAdd(a, CNT_W'(DEPTH) - b);
  endfunction

  // Rename path
  logic [LREG_W-1:0] off;
  logic              isStacked;
  assign off        = logReg - LREG_W'(GLOBALS);
  assign isStacked  = logReg >= LREG_W'(GLOBALS);
  assign regIllegal = isStacked && (CMP_W'(off) >= CMP_W'(curSize));

  always_comb begin
    if (!isStacked)      physReg = PHYS_W'(logReg);
    else if (regIllegal) physReg = '0;
    else                 physReg = PHYS_W'(GLOBALS) + PHYS_W'(wrapAdd(base, CNT_W'(off)));
  end

  // Status to control
  assign overFull     = resident > CNT_W'(DEPTH);
  assign residentZero = resident == '0;
  assign fillPending  = fillLeft != '0;

  // Memory and register file side
  assign memAddr = st.spillFire || overFull || !fillPending ? bsp : bsp + ADDR_W'(fillOff);
  assign rfRdIdx = PHYS_W'(GLOBALS) + PHYS_W'(bottom);
  assign rfWrIdx = PHYS_W'(GLOBALS) + PHYS_W'(wrapAdd(bottom, fillOff));

  // Return bookkeeping
  logic [CNT_W-1:0] callSz, retSz, callerRes, missing;
  assign callSz    = CNT_W'(callSize);
  assign retSz     = CNT_W'(retSize);
  assign callerRes = resident - curSize;
  assign missing   = (retSz > callerRes) ? retSz - callerRes : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base     <= '0;
      bottom   <= '0;
      curSize  <= '0;
      resident <= '0;
      fillLeft <= '0;
      fillOff  <= '0;
      bsp      <= ADDR_W'(BS_BASE);
    end else begin
      if (st.callAcc) begin
        base     <= wrapAdd(base, curSize);
        curSize  <= callSz;
        resident <= resident + callSz;
      end
      if (st.flushAcc) begin
        base    <= wrapAdd(base, curSize);
        curSize <= '0;
      end
      if (st.retAcc) begin
        base    <= wrapSub(base, retSz);
        curSize <= retSz;
        if (missing != '0) begin
          resident <= retSz;
          bottom   <= wrapSub(bottom, missing);
          bsp      <= bsp - ADDR_W'(missing);
          fillLeft <= missing;
          fillOff  <= '0;
        end else begin
          resident <= callerRes;
        end
      end
      if (st.spillFire) begin
        bottom   <= wrapAdd(bottom, CNT_W'(1));
        resident <= resident - 1'b1;
        bsp      <= bsp + 1'b1;
      end
      if (st.fillFire) begin
        fillLeft <= fillLeft - 1'b1;
        fillOff  <= fillOff + 1'b1;
      end
    end
  end

  p_idle_fits_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (resident <= CNT_W'(DEPTH) && resident >= curSize));
  p_spill_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.spillFire ##1 st.spillFire |-> memAddr == $past(memAddr) + 1'b1);
  p_fill_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.fillFire ##1 st.fillFire |-> memAddr == $past(memAddr) + 1'b1);
  p_stack_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isStacked && !regIllegal) |-> physReg >= PHYS_W'(GLOBALS));
  p_global_ident_r1: assert property (@(posedge clk) disable iff (!rstN)
    !isStacked |-> !regIllegal);
endmodule

// File: rtl/stack_frame_engine.sv
module stack_frame_engine
  import sfe_pkg::*;
#(
  parameter int          GLOBALS = 32,
  parameter int          DEPTH   = 16,
  parameter int          LREG_W  = 7,
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] BS_BASE = 16'h0100,
  localparam int         PHYS_W  = $clog2(GLOBALS + DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callValid,
  input  logic [LREG_W-1:0] callSize,
  input  logic              retValid,
  input  logic [LREG_W-1:0] retSize,
  input  logic              flushValid,
  output logic              busy,
  input  logic [LREG_W-1:0] logReg,
  output logic [PHYS_W-1:0] physReg,
  output logic              regIllegal,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [PHYS_W-1:0] rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [PHYS_W-1:0] rfWrIdx,
  output logic [DATA_W-1:0] rfWrData
);
  sfeStrobe_t st;
  logic overFull, residentZero, fillPending;

  sfe_ctrl #(.DEPTH(DEPTH), .LREG_W(LREG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .callValid(callValid), .callSize(callSize),
    .retValid(retValid), .retSize(retSize), .flushValid(flushValid),
    .overFull(overFull), .residentZero(residentZero), .fillPending(fillPending),
    .memReady(memReady), .st(st), .busy(busy),
    .memValid(memValid), .memWrite(memWrite)
  );

  sfe_datapath #(.GLOBALS(GLOBALS), .DEPTH(DEPTH), .LREG_W(LREG_W),
                 .ADDR_W(ADDR_W), .BS_BASE(BS_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busy(busy),
    .callSize(callSize), .retSize(retSize), .logReg(logReg),
    .overFull(overFull), .residentZero(residentZero), .fillPending(fillPending),
    .physReg(physReg), .regIllegal(regIllegal), .memAddr(memAddr),
    .rfRdIdx(rfRdIdx), .rfWrIdx(rfWrIdx)
  );

  assign memWData = rfRdData;
  assign rfWrData = memRData;
  assign rfWrEn   = st.fillFire;
endmodule

// File: tb/stack_frame_engine_tb.sv
module stack_frame_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        callValid = 1'b0, retValid = 1'b0, flushValid = 1'b0;
  logic [6:0]  callSize = '0, retSize = '0, logReg = '0;
  logic        busy, regIllegal, memValid, memWrite, rfWrEn;
  logic [5:0]  physReg, rfRdIdx, rfWrIdx;
  logic [15:0] memAddr;
  logic [31:0] memWData, memRData, rfRdData, rfWrData;
  logic        memReady;
  logic        slowMem = 1'b0;
  logic [3:0]  cyc = '0;

  logic [31:0] rf [48];
  logic [31:0] mem [512];
  logic [15:0] rdLog [32];
  int nWr = 0, nRd = 0, nChk = 0, nErr = 0;
  logic        tbWrEn = 1'b0;
  logic [5:0]  tbWrIdx = '0;
  logic [31:0] tbWrData = '0;

  always #2.5 clk = ~clk;

  stack_frame_engine u_dut (
    .clk(clk), .rstN(rstN), .callValid(callValid), .callSize(callSize),
    .retValid(retValid), .retSize(retSize), .flushValid(flushValid), .busy(busy),
    .logReg(logReg), .physReg(physReg), .regIllegal(regIllegal),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData)
  );

  assign memReady = !slowMem || cyc[0];
  assign rfRdData = rf[rfRdIdx];
  assign memRData = mem[memAddr[8:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (tbWrEn) rf[tbWrIdx] <= tbWrData;
    if (rfWrEn) rf[rfWrIdx] <= rfWrData;
    if (memValid && memReady) begin
      if (memWrite) begin
        mem[memAddr[8:0]] <= memWData;
        nWr <= nWr + 1;
      end else begin
        rdLog[nRd[4:0]] <= memAddr;
        nRd <= nRd + 1;
      end
    end
  end

  // logReg, expected physReg, expected illegal
  localparam logic [13:0] VEC [8] = '{
    {7'd0,   6'd0,  1'b0}, {7'd17,  6'd17, 1'b0}, {7'd31, 6'd31, 1'b0},
    {7'd32,  6'd32, 1'b0}, {7'd34,  6'd34, 1'b0}, {7'd36, 6'd36, 1'b0},
    {7'd37,  6'd0,  1'b1}, {7'd127, 6'd0,  1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic probe(input logic [6:0] r, output logic [5:0] p, output logic ill);
    @(negedge clk);
    logReg = r;
    #1;
    p = physReg;
    ill = regIllegal;
  endtask

  task automatic wrLog(input logic [6:0] r, input logic [31:0] v);
    logic [5:0] p; logic ill;
    probe(r, p, ill);
    tbWrEn = 1'b1; tbWrIdx = p; tbWrData = v;
    @(negedge clk);
    tbWrEn = 1'b0;
  endtask

  task automatic rdLog32(input logic [6:0] r, output logic [31:0] v);
    logic [5:0] p; logic ill;
    probe(r, p, ill);
    v = rf[p];
  endtask

  task automatic cmd(input bit c, input bit rt, input bit f,
                     input logic [6:0] cs, input logic [6:0] rs);
    @(negedge clk);
    callValid = c; retValid = rt; flushValid = f; callSize = cs; retSize = rs;
    @(negedge clk);
    callValid = 1'b0; retValid = 1'b0; flushValid = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    #1ms;
    nChk++; nErr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    logic [5:0] p; logic ill; int n, w0, r0; logic [31:0] v;
    for (int i = 0; i < 48; i++) rf[i] = '0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    @(negedge clk);
    check(!busy && !memValid, "R10 idle after reset", int'(busy || memValid), 0);
    probe(7'd5, p, ill);
    check(p == 6'd5 && !ill, "R1 global r5", p, 5);
    probe(7'd32, p, ill);
    check(ill && p == 0, "R10 empty frame r32 illegal", ill, 1);

    // R3 first call, then table walk (R1/R2)
    cmd(1, 0, 0, 7'd5, 7'd0);
    waitIdle(n);
    foreach (VEC[i]) begin
      probe(VEC[i][13:7], p, ill);
      check(p == VEC[i][6:1] && ill == VEC[i][0],
            (VEC[i][13:7] < 7'd32) ? "R1 table" : "R2 table", p, int'(VEC[i][6:1]));
    end
    for (int i = 0; i < 5; i++) wrLog(7'(32 + i), 32'hA0 + i);

    // R3 second call without overflow
    w0 = nWr;
    cmd(1, 0, 0, 7'd8, 7'd0);
    waitIdle(n);
    check(n == 0 && nWr == w0, "R3 no spill", nWr - w0, 0);
    probe(7'd32, p, ill);
    check(p == 6'd37, "R3 base moved", p, 37);
    for (int i = 0; i < 8; i++) wrLog(7'(32 + i), 32'hB0 + i);

    // R4 overflow spill of four oldest entries
    w0 = nWr;
    cmd(1, 0, 0, 7'd7, 7'd0);
    waitIdle(n);
    check(n == 4, "R4 spill cycles", n, 4);
    check(nWr - w0 == 4, "R4 spill count", nWr - w0, 4);
    for (int i = 0; i < 4; i++)
      check(mem[9'h100 + i] == 32'hA0 + i, "R4 R10 spill data", int'(mem[9'h100 + i]), 'hA0 + i);
    probe(7'd32, p, ill);
    check(p == 6'd45, "R2 r32 base 13", p, 45);
    probe(7'd35, p, ill);
    check(p == 6'd32, "R2 wrap", p, 32);
    probe(7'd38, p, ill);
    check(!ill, "R2 last legal", ill, 0);
    probe(7'd39, p, ill);
    check(ill, "R2 beyond frame", ill, 1);
    for (int i = 0; i < 7; i++) wrLog(7'(32 + i), 32'hC0 + i);

    // R5 return without fill
    r0 = nRd;
    cmd(0, 1, 0, 7'd0, 7'd8);
    waitIdle(n);
    check(nRd == r0 && n == 0, "R5 resident return", nRd - r0, 0);
    rdLog32(7'd32, v);
    check(v == 32'hB0, "R5 caller r32", int'(v), 'hB0);
    rdLog32(7'd39, v);
    check(v == 32'hB7, "R5 caller r39", int'(v), 'hB7);

    // R5/R9 return with fill over a slow memory
    slowMem = 1'b1;
    r0 = nRd;
    cmd(0, 1, 0, 7'd0, 7'd5);
    waitIdle(n);
    check(nRd - r0 == 4, "R9 fill count slow", nRd - r0, 4);
    check(rdLog[r0[4:0]] == 16'h100, "R5 oldest first", int'(rdLog[r0[4:0]]), 'h100);
    check(rdLog[5'(r0 + 3)] == 16'h103, "R5 last fill addr", int'(rdLog[5'(r0 + 3)]), 'h103);
    for (int i = 0; i < 5; i++) begin
      rdLog32(7'(32 + i), v);
      check(v == 32'hA0 + i, "R5 restored", int'(v), 'hA0 + i);
    end

    // R6 flush, R7 call while busy ignored
    w0 = nWr;
    cmd(0, 0, 1, 7'd0, 7'd0);
    check(busy, "R6 busy during flush", busy, 1);
    cmd(1, 0, 0, 7'd3, 7'd0);
    waitIdle(n);
    check(nWr - w0 == 5, "R6 flush count", nWr - w0, 5);
    for (int i = 0; i < 5; i++)
      check(mem[9'h100 + i] == 32'hA0 + i, "R6 flush data", int'(mem[9'h100 + i]), 'hA0 + i);
    probe(7'd32, p, ill);
    check(ill, "R6 R7 frame empty after flush", ill, 1);

    // R6 restore after clobbering the register file
    slowMem = 1'b0;
    for (int i = 32; i < 48; i++) begin
      @(negedge clk); tbWrEn = 1'b1; tbWrIdx = 6'(i); tbWrData = '0;
    end
    @(negedge clk); tbWrEn = 1'b0;
    cmd(0, 1, 0, 7'd0, 7'd5);
    waitIdle(n);
    for (int i = 0; i < 5; i++) begin
      rdLog32(7'(32 + i), v);
      check(v == 32'hA0 + i, "R6 restore", int'(v), 'hA0 + i);
    end

    // R7 priority: call beats return
    cmd(1, 1, 0, 7'd2, 7'd9);
    waitIdle(n);
    probe(7'd33, p, ill);
    check(!ill && p == 6'd38, "R7 call wins", p, 38);
    probe(7'd34, p, ill);
    check(ill, "R7 frame size 2", ill, 1);

    // R8 oversized call and return ignored
    w0 = nWr; r0 = nRd;
    cmd(1, 0, 0, 7'd17, 7'd0);
    waitIdle(n);
    cmd(0, 1, 0, 7'd0, 7'd17);
    waitIdle(n);
    probe(7'd32, p, ill);
    check(p == 6'd37 && !ill, "R8 frame unchanged", p, 37);
    probe(7'd34, p, ill);
    check(ill, "R8 size unchanged", ill, 1);
    check(nWr == w0 && nRd == r0, "R8 no traffic", (nWr - w0) + (nRd - r0), 0);

    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end
endmodule